// File: doc/BRIEF.md
# Extender-Steered Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two N-bit operands (N defaults to 4). A 3-bit function select picks one of eight operations. Four are arithmetic: addition, subtraction, decrement and pass-through of B. Four are logical or move operations: pass-through of A, complement of A, exclusive-or and not-and. It returns an N-bit result and a carry-out. Results wrap modulo 2^N.

Every operation goes through one shared ripple-carry adder. Three small conditioning stages set up the adder for each select value. The first prepares the adder's left operand from A and B and does all the bitwise work. The second prepares the right operand from B: zero, B, the inverse of B, or all ones. The third supplies the adder's carry-in. A datapath that needs an ALU for a simple processor instantiates the block and decodes its instruction field into the select.

Top module: `alu_ext_top`

## Requirements
- R1: With select 3'b000 the result equals A and the carry-out is 0.
- R2: With select 3'b001 the result equals B and the carry-out is 0.
- R3: With select 3'b010 the result is (A + B) mod 2^N and the carry-out is bit N of the full sum.
- R4: With select 3'b011 the result is the bitwise inverse of A and the carry-out is 0.
- R5: With select 3'b100 the result is A XOR B and the carry-out is 0.
- R6: With select 3'b101 the result is the bitwise inverse of (A AND B) and the carry-out is 0.
- R7: With select 3'b110 the result is (A - 1) mod 2^N, and the carry-out is 1 exactly when A is nonzero.
- R8: With select 3'b111 the result is (A - B) mod 2^N, and the carry-out is 1 exactly when A >= B (unsigned).
- R9: The outputs follow the inputs without any clock. A new input combination shows its result in the same cycle it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Function select, encoded as in R1 to R8 |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| res_o | output | WIDTH | Operation result, modulo 2^WIDTH |
| cout_o | output | 1 | Final carry of the shared adder |

## Verification
Whenever the inputs are known, immediate assertions inside the top module compare the adder's outputs with the operands for every select value. This covers the carry-out meaning of decrement and subtraction (R7, R8), and a carry of zero for every logic and move operation. These checks relate the operands to the adder's output across the extender stages. They cannot show that the settled ports are the values a separate calculation predicts, nor that a change of input alone updates them (R9). The bench's exhaustive per-select sweeps and its directed boundary cases cover that: zero minus one, equal operands, and the largest sum.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

  typedef enum logic [2:0] {
    OP_PASS_A = 3'b000,
    OP_PASS_B = 3'b001,
    OP_ADD    = 3'b010,
    OP_NOT_A  = 3'b011,
    OP_XOR    = 3'b100,
    OP_NAND   = 3'b101,
    OP_DEC    = 3'b110,
    OP_SUB    = 3'b111
  } alu_op_e;

  // One full-adder slice, split in sum and carry
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // True for operations whose result comes entirely from the left-side stage
  function automatic logic is_logic_op(input alu_op_e op);
    return (op == OP_PASS_A) || (op == OP_NOT_A) || (op == OP_XOR) || (op == OP_NAND);
  endfunction

endpackage

// File: rtl/alu_left_ext.sv
// Left adder operand: A, a bitwise function of A and B, or zero
module alu_left_ext
  import alu_ext_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   left_opnd
);
  always_comb begin
    unique case (op)
      OP_PASS_B: left_opnd = '0;
      OP_NOT_A:  left_opnd = ~a;
      OP_XOR:    left_opnd = a ^ b;
      OP_NAND:   left_opnd = ~(a & b);
      default:   left_opnd = a;   // pass A, add, decrement, subtract
    endcase
  end
endmodule

// File: rtl/alu_right_ext.sv
// Right adder operand: zero, B, inverted B or all ones
module alu_right_ext
  import alu_ext_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   right_opnd
);
  always_comb begin
    unique case (op)
      OP_PASS_B, OP_ADD: right_opnd = b;
      OP_SUB:            right_opnd = ~b;
      OP_DEC:            right_opnd = '1;
      default:           right_opnd = '0;
    endcase
  end
endmodule

// File: rtl/alu_carry_ext.sv
// Adder carry-in: set only for subtraction (two's-complement of B)
module alu_carry_ext
  import alu_ext_pkg::*;
(
  input  alu_op_e op,
  output logic    cin
);
  always_comb cin = (op == OP_SUB);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
  import alu_ext_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign sum[i]     = fa_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = fa_carry(x[i], y[i], chain[i]);
  end

  assign cout = chain[WIDTH];
endmodule

// File: rtl/alu_ext_top.sv
module alu_ext_top
  import alu_ext_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  alu_op_e          op;
  logic [WIDTH-1:0] left_opnd;
  logic [WIDTH-1:0] right_opnd;
  logic             carry_in;
  logic [WIDTH-1:0] adder_sum;
  logic             adder_cout;

  assign op = alu_op_e'(op_sel);

  alu_left_ext #(.WIDTH(WIDTH)) u_left (
    .op(op), .a(opnd_a), .b(opnd_b), .left_opnd(left_opnd)
  );

  alu_right_ext #(.WIDTH(WIDTH)) u_right (
    .op(op), .b(opnd_b), .right_opnd(right_opnd)
  );

  alu_carry_ext u_carry (
    .op(op), .cin(carry_in)
  );

  alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x(left_opnd), .y(right_opnd), .cin(carry_in),
    .sum(adder_sum), .cout(adder_cout)
  );

  assign res_o  = adder_sum;
  assign cout_o = adder_cout;

  // Checks across the extender stages and the shared adder
  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
      if (op == OP_PASS_A)
        AST_PASS_A: assert (adder_sum == opnd_a && !adder_cout) else $error("pass A"); // R1
      if (op == OP_PASS_B)
        AST_PASS_B: assert (adder_sum == opnd_b && !adder_cout) else $error("pass B"); // R2
      if (op == OP_ADD)
        AST_ADD_WIDE: assert ({adder_cout, adder_sum} == ({1'b0, opnd_a} + {1'b0, opnd_b})) else $error("add"); // R3
      if (op == OP_NOT_A)
        AST_NOT_A: assert ((adder_sum ^ opnd_a) == ALL_ONES && !adder_cout) else $error("not A"); // R4
      if (op == OP_XOR)
        AST_XOR_ONLY: assert ((adder_sum ^ opnd_b) == opnd_a && !adder_cout) else $error("xor"); // R5
      if (op == OP_NAND)
        AST_NAND_ONLY: assert ((adder_sum | opnd_a) == ALL_ONES && !adder_cout) else $error("nand"); // R6
      if (op == OP_DEC)
        AST_DEC_BORROW: assert (adder_cout == (opnd_a != '0)) else $error("dec carry"); // R7
      if (op == OP_SUB)
        AST_SUB_BORROW: assert (adder_cout == (opnd_a >= opnd_b)) else $error("sub carry"); // R8
      if (is_logic_op(op))
        AST_LOGIC_NO_CIN: assert (!carry_in && right_opnd == '0) else $error("logic path"); // R4 R5 R6
    end
  end
endmodule

// File: tb/alu_ext_top_bench.sv
module alu_ext_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic [2:0]   op_sel;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] res_o;
  logic         cout_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_ext_top #(.WIDTH(W)) u_alu_ext_top (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_o(res_o), .cout_o(cout_o)
  );

  task automatic check(input string req, input int exp_res, input int exp_c);
    tests_run++;
    if (int'(res_o) != exp_res || int'(cout_o) != exp_c) begin
      tests_failed++;
      $display("FAIL %s sel=%b a=%0d b=%0d: got res=%0d c=%0d, expected res=%0d c=%0d",
               req, op_sel, opnd_a, opnd_b, res_o, cout_o, exp_res, exp_c);
    end
  endtask

  task automatic apply(input int sel, input int a, input int b);
    @(posedge clk);
    op_sel = 3'(sel);
    opnd_a = W'(a);
    opnd_b = W'(b);
    @(negedge clk);
  endtask

  // Expected value computed with plain integer arithmetic
  task automatic sweep(input int sel, input string req);
    for (int a = 0; a < SPAN; a++) begin
      for (int b = 0; b < SPAN; b++) begin
        int r;
        int c;
        c = 0;
        case (sel)
          0: r = a;
          1: r = b;
          2: begin r = (a + b) % SPAN; c = (a + b) / SPAN; end
          3: r = SPAN - 1 - a;
          4: r = a ^ b;
          5: r = (SPAN - 1) - (a & b);
          6: begin r = (a + SPAN - 1) % SPAN; c = (a != 0) ? 1 : 0; end
          default: begin r = (a - b + SPAN) % SPAN; c = (a >= b) ? 1 : 0; end
        endcase
        apply(sel, a, b);
        check(req, r, c);
      end
    end
  endtask

  task automatic test_idle_state;
    apply(0, 0, 0);
    check("R1", 0, 0);
  endtask

  task automatic test_pass_a; sweep(0, "R1"); endtask
  task automatic test_pass_b; sweep(1, "R2"); endtask
  task automatic test_add;    sweep(2, "R3"); endtask
  task automatic test_not_a;  sweep(3, "R4"); endtask
  task automatic test_xor;    sweep(4, "R5"); endtask
  task automatic test_nand;   sweep(5, "R6"); endtask
  task automatic test_dec;    sweep(6, "R7"); endtask
  task automatic test_sub;    sweep(7, "R8"); endtask

  task automatic test_corners;
    apply(6, 0, 9);   check("R7", 15, 0);  // zero minus one wraps, no carry
    apply(7, 5, 5);   check("R8", 0, 1);   // equal operands
    apply(7, 0, 15);  check("R8", 1, 0);   // largest borrow
    apply(2, 15, 15); check("R3", 14, 1);  // largest sum
  endtask

  // Inputs change with no other event; result must follow within the cycle
  task automatic test_comb_follow;
    apply(2, 3, 4); check("R9", 7, 0);
    @(posedge clk);
    #1 opnd_b = 4'd12;
    #1;
    tests_run++;
    if (res_o != 4'd15 || cout_o != 1'b0) begin
      tests_failed++;
      $display("FAIL R9 comb update: got res=%0d c=%0d, expected res=15 c=0", res_o, cout_o);
    end
    #1 op_sel = 3'b100;
    #1;
    tests_run++;
    if (res_o != 4'd15 || cout_o != 1'b0) begin
      tests_failed++;
      $display("FAIL R9 select change: got res=%0d c=%0d, expected res=15 c=0", res_o, cout_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      tests_failed++;
      $display("FAIL watchdog expired: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    op_sel = '0; opnd_a = '0; opnd_b = '0;
    test_idle_state();
    test_pass_a();
    test_pass_b();
    test_add();
    test_not_a();
    test_xor();
    test_nand();
    test_dec();
    test_sub();
    test_corners();
    test_comb_follow();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule